// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Device Emulator

This block models the device side of a 128-word by 8-bit nonvolatile memory that a host reaches over three wires: a serial clock, a chip-enable, and one bidirectional data line. The data line is split into an input, an output and an output-enable. A fast system clock samples every wire through a synchronizer, so the serial clock and chip-enable may run at any speed well below the system clock.

While chip-enable is high, each serial clock rising edge shifts one bit from the data line into a 16-bit command register. Bits arrive least significant first. The register holds the data byte in bits 7:0, the word address in bits 14:8 and the control bit in bit 15. Chip-enable high also returns the sequencer to idle but leaves the command register untouched. The falling edge of chip-enable starts the operation. With control bit 0 the block reads the addressed word back. With control bit 1, the level of the data line at that falling edge chooses erase (1) or write (0). The update is then triggered by one start pulse on the serial clock.

A programming operation raises `busy` for a parameterised number of system cycles. The array is updated when that count runs out or when chip-enable returns high, whichever happens first. A test input turns an erase of address 0 into an erase of the whole array.

Top module: `serial_eeprom_emu`

## Requirements
- R1: After reset, `dq_oe` and `busy` are 0 and every word of the array reads 0xFF.
- R2: While chip-enable is high, each serial clock rising edge shifts in one data-line bit, least significant bit first. An 8-bit command is A0..A6 then the control bit. A 16-bit command is D0..D7, then A0..A6, then the control bit. Each address bit selects its own word.
- R3: Control bit 0 selects a read. The first serial clock after chip-enable falls loads the addressed word. On the falling edge of that clock, `dq_oe` goes to 1 and `dq_out` shows D0. Each later falling edge shows the next bit, up to D7.
- R4: When chip-enable goes high, `dq_oe` returns to 0. The data-line level during a read changes neither the bits read out nor the array.
- R5: Control bit 1 with the data line at 1 when chip-enable falls, followed by a start pulse, sets the addressed word to 0xFF. Other words are left as they were.
- R6: Control bit 1 with the data line at 0 when chip-enable falls, followed by a start pulse, sets the addressed word to the old word AND the data byte.
- R7: `busy` goes to 1 after the falling edge of the start pulse. Without a chip-enable rise, it stays 1 for `PROG_CYCLES` system cycles and then returns to 0 with the update applied.
- R8: If chip-enable rises while `busy` is 1, the update is applied at once and `busy` returns to 0.
- R9: The command register keeps its contents across chip-enable high. A write that directly follows an erase, with no new serial entry, stores the previously entered data byte.
- R10: With `test_in` at 1 when chip-enable falls, an erase of address 0 sets every word to 0xFF. With `test_in` at 0, the same erase changes only word 0.
- R11: If chip-enable rises before any start pulse follows a control-bit-1 command, the array is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_in | input | 1 | Serial shift and start clock |
| ce_in | input | 1 | Chip-enable; high = shift and idle, falling edge starts an operation |
| dq_in | input | 1 | Data line input level |
| test_in | input | 1 | Enables whole-array erase |
| dq_out | output | 1 | Data line output value |
| dq_oe | output | 1 | Data line drive enable |
| busy | output | 1 | Programming in progress |

## Verification
Every wire edge reaches the sequencer after the two synchronizer stages plus one edge-detect register. An output therefore changes three system cycles after the bench moves a wire. The bench holds each serial clock and chip-enable level for ten system cycles and samples `dq_out`, `dq_oe` and `busy` at the end of that hold, well clear of the three-cycle latency. It checks `busy` a few cycles after the start pulse falls and again after `PROG_CYCLES` plus margin has passed. It checks array contents only through later reads, which it compares with a bench model updated under the requirement rules. Random operations with a fixed seed are mixed with directed cases for AND-writes, erase followed by write, early chip-enable rise, a missing start pulse and total erase.

// File: rtl/eep_pkg.sv
`timescale 1ns/1ps
package eep_pkg;
    parameter int ADDR_W = 7;
    parameter int DATA_W = 8;
    localparam int WORDS = 1 << ADDR_W;
    localparam int CMD_W = DATA_W + ADDR_W + 1;

    typedef enum logic [2:0] {
        ST_IDLE, ST_RD_WAIT, ST_RD_FIRST, ST_RD_SHIFT,
        ST_PG_WAIT, ST_PG_ARM, ST_PROG, ST_DONE
    } seq_state_e;

    typedef enum logic [1:0] {
        OP_NONE, OP_ERASE, OP_WRITE, OP_ERASE_ALL
    } op_kind_e;

    typedef struct packed {
        op_kind_e            kind;
        logic [ADDR_W-1:0]   addr;
        logic [DATA_W-1:0]   data;
    } mem_op_t;

    function automatic logic [ADDR_W-1:0] cmd_addr(input logic [CMD_W-1:0] s);
        return s[DATA_W +: ADDR_W];
    endfunction

    function automatic logic cmd_ctrl(input logic [CMD_W-1:0] s);
        return s[CMD_W-1];
    endfunction

    function automatic logic [DATA_W-1:0] cmd_data(input logic [CMD_W-1:0] s);
        return s[DATA_W-1:0];
    endfunction
endpackage

// File: rtl/eep_sync.sv
`timescale 1ns/1ps
module eep_sync #(
    parameter int          W       = 4,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) chain[s] <= RST_VAL;
        end else begin
            chain[0] <= d;
            for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/eep_shreg.sv
`timescale 1ns/1ps
module eep_shreg
    import eep_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              shift_en,
    input  logic              bit_in,
    input  logic              load_en,
    input  logic [DATA_W-1:0] load_byte,
    input  logic              rot_en,
    output logic [CMD_W-1:0]  sr_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q <= '0;
        end else if (load_en) begin
            sr_q[DATA_W-1:0] <= load_byte;
        end else if (rot_en) begin
            sr_q[DATA_W-1:0] <= {sr_q[0], sr_q[DATA_W-1:1]};
        end else if (shift_en) begin
            sr_q <= {bit_in, sr_q[CMD_W-1:1]};
        end
    end
endmodule

// File: rtl/eep_array.sv
`timescale 1ns/1ps
module eep_array
    import eep_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  mem_op_t           op,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_word
);
    logic [DATA_W-1:0] words [WORDS];

    generate
        for (genvar i = 0; i < WORDS; i++) begin : g_word
            logic [DATA_W-1:0] word_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    word_q <= '1;
                end else if (op.kind == OP_ERASE_ALL) begin
                    word_q <= '1;
                end else if (op.addr == ADDR_W'(i)) begin
                    if (op.kind == OP_ERASE)      word_q <= '1;
                    else if (op.kind == OP_WRITE) word_q <= word_q & op.data;
                end
            end
            assign words[i] = word_q;
        end
    endgenerate

    assign rd_word = words[rd_addr];

    // R5: a word erase leaves the addressed word all ones
    p_erase_word_r5: assert property (@(posedge clk) disable iff (rst)
        $past(op.kind == OP_ERASE) |-> words[$past(op.addr)] == '1);

    // R6: a write keeps only bits that are 1 in both old word and data
    p_write_and_r6: assert property (@(posedge clk) disable iff (rst)
        $past(op.kind == OP_WRITE) |->
            words[$past(op.addr)] == ($past(words[op.addr]) & $past(op.data)));

    // R10: total erase reaches the first and the last word
    p_total_erase_r10: assert property (@(posedge clk) disable iff (rst)
        $past(op.kind == OP_ERASE_ALL) |-> (words[0] == '1 && words[WORDS-1] == '1));
endmodule

// File: rtl/serial_eeprom_emu.sv
`timescale 1ns/1ps
module serial_eeprom_emu
    import eep_pkg::*;
#(
    parameter int PROG_CYCLES = 1000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sclk_in,
    input  logic ce_in,
    input  logic dq_in,
    input  logic test_in,
    output logic dq_out,
    output logic dq_oe,
    output logic busy
);
    localparam int CNT_W = $clog2(PROG_CYCLES + 1);

    logic [3:0]  pins_s;
    logic        ce_s, sclk_s, dq_s, tst_s;
    logic        ce_p, sclk_p;
    logic        ce_rise, ce_fall, sck_rise, sck_fall;
    seq_state_e  state;
    logic        is_erase, is_total, oe_q;
    logic [CNT_W-1:0] cnt;
    logic [CMD_W-1:0]  sr;
    logic [DATA_W-1:0] rd_word;
    logic        shift_en, load_en, rot_en, apply;
    mem_op_t     op;

    eep_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b0001)) u_sync (
        .clk(clk), .rst(rst),
        .d({test_in, dq_in, sclk_in, ce_in}),
        .q(pins_s)
    );
    assign {tst_s, dq_s, sclk_s, ce_s} = pins_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            ce_p   <= 1'b1;
            sclk_p <= 1'b0;
        end else begin
            ce_p   <= ce_s;
            sclk_p <= sclk_s;
        end
    end

    assign ce_rise  = ce_s & ~ce_p;
    assign ce_fall  = ~ce_s & ce_p;
    assign sck_rise = sclk_s & ~sclk_p;
    assign sck_fall = ~sclk_s & sclk_p;

    assign shift_en = ce_s && state == ST_IDLE && sck_rise;
    assign load_en  = !ce_rise && state == ST_RD_WAIT && sck_rise;
    assign rot_en   = !ce_rise && state == ST_RD_SHIFT && sck_fall;
    assign apply    = state == ST_PROG && (ce_rise || cnt == '0);

    eep_shreg u_shreg (
        .clk(clk), .rst(rst),
        .shift_en(shift_en), .bit_in(dq_s),
        .load_en(load_en), .load_byte(rd_word),
        .rot_en(rot_en), .sr_q(sr)
    );

    always_comb begin
        op.addr = cmd_addr(sr);
        op.data = cmd_data(sr);
        if (!apply)        op.kind = OP_NONE;
        else if (is_total) op.kind = OP_ERASE_ALL;
        else if (is_erase) op.kind = OP_ERASE;
        else               op.kind = OP_WRITE;
    end

    eep_array u_array (
        .clk(clk), .rst(rst),
        .op(op), .rd_addr(cmd_addr(sr)), .rd_word(rd_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            is_erase <= 1'b0;
            is_total <= 1'b0;
            oe_q     <= 1'b0;
            cnt      <= '0;
        end else if (ce_rise) begin
            state <= ST_IDLE;
            oe_q  <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (ce_fall) begin
                    state    <= cmd_ctrl(sr) ? ST_PG_WAIT : ST_RD_WAIT;
                    is_erase <= dq_s;
                    is_total <= tst_s && dq_s && cmd_addr(sr) == '0;
                end
                ST_RD_WAIT:  if (sck_rise) state <= ST_RD_FIRST;
                ST_RD_FIRST: if (sck_fall) begin
                    state <= ST_RD_SHIFT;
                    oe_q  <= 1'b1;
                end
                ST_RD_SHIFT: state <= ST_RD_SHIFT;
                ST_PG_WAIT:  if (sck_rise) state <= ST_PG_ARM;
                ST_PG_ARM:   if (sck_fall) begin
                    state <= ST_PROG;
                    cnt   <= CNT_W'(PROG_CYCLES - 1);
                end
                ST_PROG: begin
                    if (cnt == '0) state <= ST_DONE;
                    else           cnt   <= cnt - 1'b1;
                end
                ST_DONE: state <= ST_DONE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign dq_oe  = oe_q;
    assign dq_out = oe_q & sr[0];
    assign busy   = state == ST_PROG;

    // Checker counter: length of the current busy run
    logic [CNT_W:0] busy_run;
    always_ff @(posedge clk) begin
        if (rst)       busy_run <= '0;
        else if (busy) busy_run <= busy_run + 1'b1;
        else           busy_run <= '0;
    end

    // R4: output drive released while chip-enable stays high
    p_oe_idle_r4: assert property (@(posedge clk) disable iff (rst)
        (ce_s && ce_p) |-> !dq_oe);

    // R8: busy never outlives a chip-enable rise
    p_busy_ce_low_r8: assert property (@(posedge clk) disable iff (rst)
        busy |-> !ce_p);

    // R7: busy lasts no longer than the programming count
    p_busy_window_r7: assert property (@(posedge clk) disable iff (rst)
        busy |-> busy_run < (CNT_W+1)'(PROG_CYCLES));

    // R3: drive enable only appears after a serial clock fall
    p_oe_after_fall_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(dq_oe) |-> $past(sck_fall));
endmodule

// File: tb/test_serial_eeprom_emu.sv
`timescale 1ns/1ps
module test_serial_eeprom_emu;
    localparam int PROG = 40;
    localparam int H    = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sclk = 1'b0, ce = 1'b1, dq = 1'b0, tst = 1'b0;
    logic dq_out, dq_oe, busy;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [7:0] model [128];

    always #2.5 clk = ~clk;

    serial_eeprom_emu #(.PROG_CYCLES(PROG), .SYNC_STAGES(2)) i_serial_eeprom_emu (
        .clk(clk), .rst(rst), .sclk_in(sclk), .ce_in(ce), .dq_in(dq),
        .test_in(tst), .dq_out(dq_out), .dq_oe(dq_oe), .busy(busy)
    );

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send(input logic [15:0] v, input int n);
        for (int i = 0; i < n; i++) begin
            dq = v[i]; wt(H);
            sclk = 1'b1; wt(H);
            sclk = 1'b0;
        end
        wt(H);
    endtask

    // R3/R4: read a word with random data-line noise, compare to model
    task automatic read_chk(input logic [6:0] a, input string req);
        logic [7:0] got;
        logic       oe_all;
        send({8'h00, 1'b0, a}, 8);
        dq = 1'($urandom); wt(H);
        ce = 1'b0; wt(H);
        oe_all = 1'b1;
        for (int k = 0; k < 8; k++) begin
            dq = 1'($urandom);
            sclk = 1'b1; wt(H);
            sclk = 1'b0; wt(H);
            got[k] = dq_out;
            oe_all = oe_all & dq_oe;
        end
        chk({req, " R3 oe"}, 32'(oe_all), 32'd1);
        chk({req, " R3 data"}, 32'(got), 32'(model[a]));
        ce = 1'b1; wt(H);
        chk("R4 oe released", 32'(dq_oe), 32'd0);
    endtask

    // program: erase=1/write=0; pulse=0 omits start pulse; early=1 raises ce while busy
    task automatic prog(input logic erase, input bit pulse, input bit early);
        dq = erase; wt(H);
        ce = 1'b0; wt(H);
        if (pulse) begin
            sclk = 1'b1; wt(H);
            sclk = 1'b0; wt(5);
            chk("R7 busy after start", 32'(busy), 32'd1);
            if (!early) begin
                wt(20);
                chk("R7 busy held", 32'(busy), 32'd1);
                wt(PROG);
                chk("R7 busy ends", 32'(busy), 32'd0);
            end
        end
        ce = 1'b1; wt(H);
        if (early) chk("R8 busy drops at ce rise", 32'(busy), 32'd0);
    endtask

    task automatic do_write(input logic [6:0] a, input logic [7:0] d);
        send({1'b1, a, d}, 16);
        prog(1'b0, 1'b1, 1'b0);
        model[a] = model[a] & d;
    endtask

    task automatic do_erase(input logic [6:0] a);
        send({8'h00, 1'b1, a}, 8);
        prog(1'b1, 1'b1, 1'b0);
        model[a] = 8'hFF;
    endtask

    initial begin
        for (int i = 0; i < 128; i++) model[i] = 8'hFF;
        void'($urandom(32'd2024));
        wt(10);
        rst = 1'b0;
        wt(10);
        chk("R1 busy", 32'(busy), 32'd0);
        chk("R1 oe", 32'(dq_oe), 32'd0);
        read_chk(7'd0, "R1 word0");
        read_chk(7'd127, "R1 word127");

        // R2: single-bit addresses must hit distinct words
        do_write(7'd1, 8'h11);
        do_write(7'd64, 8'h22);
        read_chk(7'd1, "R2 addr1");
        read_chk(7'd64, "R2 addr64");
        read_chk(7'd0, "R2 addr0 untouched");

        // R6: write is an AND with the old word
        do_write(7'd3, 8'h5A);
        do_write(7'd3, 8'h0F);
        read_chk(7'd3, "R6 and-write");

        // R5: erase-only command
        do_erase(7'd3);
        read_chk(7'd3, "R5 erase");
        read_chk(7'd1, "R5 neighbour kept");

        // R9: erase then write with no new serial entry
        do_write(7'd9, 8'h00);
        send({1'b1, 7'd9, 8'hC3}, 16);
        prog(1'b1, 1'b1, 1'b0);
        prog(1'b0, 1'b1, 1'b0);
        model[9] = 8'hC3;
        read_chk(7'd9, "R9 erase-then-write");

        // R8: early chip-enable rise still applies the write
        send({1'b1, 7'd20, 8'h3C}, 16);
        prog(1'b0, 1'b1, 1'b1);
        model[20] = 8'h3C;
        read_chk(7'd20, "R8 early apply");

        // R11: no start pulse, no change
        send({1'b1, 7'd21, 8'h00}, 16);
        prog(1'b0, 1'b0, 1'b0);
        read_chk(7'd21, "R11 no pulse");

        // R10: erase of word 0 without test input affects word 0 only
        do_write(7'd0, 8'h12);
        do_erase(7'd0);
        read_chk(7'd0, "R10 word0 erased");
        read_chk(7'd64, "R10 word64 kept");

        // Random mix
        for (int n = 0; n < 40; n++) begin
            logic [6:0] a;
            logic [7:0] d;
            int sel;
            a = 7'($urandom);
            d = 8'($urandom);
            sel = $urandom_range(2, 0);
            if (sel == 0)      do_write(a, d);
            else if (sel == 1) do_erase(a);
            read_chk(a, "R6 random");
        end

        // R10: total erase with test input
        tst = 1'b1;
        send({8'h00, 1'b1, 7'd0}, 8);
        prog(1'b1, 1'b1, 1'b0);
        tst = 1'b0;
        for (int i = 0; i < 128; i++) model[i] = 8'hFF;
        read_chk(7'd1, "R10 total word1");
        read_chk(7'd20, "R10 total word20");
        read_chk(7'd64, "R10 total word64");

        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule